// File: doc/BRIEF.md
# Procedure Frame Linkage Sequencer

This block carries out the frame bookkeeping of a stack machine whose evaluation stack grows toward higher addresses while its heap grows down from the top. It holds the stack top, the base of the current frame, the frame's high-water cell, the heap floor and the program counter. A controller in front of it issues one of five frame commands at a time: reserve a frame header, transfer control into a procedure, size the frame, size its working area, and leave a procedure.

Every frame starts at its base cell with a result slot. The cells above the result slot hold, in order, the static link, the dynamic link, the saved high-water pointer and the return address. Parameters and locals follow the header. The block reaches these cells through a single-port stack memory. A read returns its data in the cycle after the request. While the block walks the static chain or moves header cells, it raises busy. When the working area would pass the heap floor, it raises a sticky exhaustion flag and then freezes.

Top module: `sfseq_top`

## Requirements
- R1: After synchronous reset: stack top = RST_SP (4), frame base = 0, high-water = RST_SP, heap floor = HEAP_TOP (240), program counter = 0, exhaustion flag low, busy low.
- R2: Reserve-header (op code 0, level difference in cmd_a[3:0]) writes three cells, one per cycle, once the chain walk is done. With b = stack top + 1, it writes the static link to b+1, then the caller's frame base to b+2, then the high-water pointer to b+3. It then adds 5 to the stack top. With a level difference of 0, the static link is the current frame base.
- R3: With a level difference n > 0, the static link is found by starting at the frame base and replacing the pointer n times by the memory cell at pointer+1. Each level takes two cycles, so busy stays high for 2n+3 cycles in total.
- R4: Transfer (op code 1, parameter count n in cmd_a, target in cmd_b) sets the frame base to stack top − n − 4. In the cycle after acceptance it writes the old program counter to that new base + 4. It then loads cmd_b into the program counter. Busy stays high for 1 cycle.
- R5: Frame sizing (op code 2, argument i in cmd_a) sets the stack top to frame base + i in the cycle after acceptance, with no memory access.
- R6: Working-area sizing (op code 3, argument j in cmd_a) sets the high-water pointer to stack top + j, provided that sum does not exceed the heap floor. A sum equal to the heap floor is accepted.
- R7: If stack top + j (computed without wrap) is greater than the heap floor, the exhaustion flag rises, the high-water pointer stays unchanged, and the flag stays high until reset.
- R8: While the exhaustion flag is high, commands cause no memory access and no register change.
- R9: Leave (op code 4, result type in cmd_a[1:0], 0 meaning no result) restores the high-water pointer from base+3, the frame base from base+2 and the program counter from base+4. The stack top becomes the old base for a nonzero type, or the old base − 1 for type 0. Busy stays high for 4 cycles.
- R10: A command presented while busy is high is dropped. With no command, the registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0..4) |
| cmd_a | input | AW | First argument (level, count, size or type) |
| cmd_b | input | AW | Second argument (transfer target) |
| busy | output | 1 | A multi-cycle command is in progress |
| mem_en | output | 1 | Stack memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Stack memory address |
| mem_wdata | output | AW | Write data |
| mem_rdata | input | AW | Read data, valid the cycle after a read |
| sp | output | AW | Stack top |
| mp | output | AW | Current frame base |
| ep | output | AW | Frame high-water pointer |
| np | output | AW | Heap floor |
| pc | output | AW | Program counter |
| exhausted | output | 1 | Sticky stack/heap collision flag |

## Verification
The bench targets several corners, each tied to a specific error:
- **Chain walk depth.** An off-by-one walk would store the wrong static link and stretch or shorten busy.
- **Exhaustion boundary.** At exactly the heap floor, an inclusive compare would raise the flag.
- **Result-type choice on leave.** An inverted test would leave the stack top one cell off.
- **Command during a walk.** A design that did not gate commands with busy would let a frame-sizing command change the stack top in mid-walk.
- **Frozen state after exhaustion.** A design that kept accepting commands would still touch memory or move registers.

Random command mixes run against a reference model and a reference memory image, so that wrapped address arithmetic is also compared.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;

    typedef enum logic [2:0] {
        OP_MARK  = 3'd0,
        OP_CALL  = 3'd1,
        OP_SETSP = 3'd2,
        OP_SETEP = 3'd3,
        OP_RET   = 3'd4
    } frame_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_WALK, S_WCAP, S_WSL, S_WDL, S_WEP,
        S_CALL, S_RA, S_RB, S_RC, S_RD
    } seq_state_e;

    localparam int unsigned HDR_CELLS = 5;
    localparam int unsigned OFS_SL    = 1;
    localparam int unsigned OFS_DL    = 2;
    localparam int unsigned OFS_EP    = 3;
    localparam int unsigned OFS_RA    = 4;

    function automatic logic keeps_result(input logic [1:0] kind);
        return kind != 2'd0;
    endfunction

endpackage

// File: rtl/sfseq_link_walker.sv
module sfseq_link_walker #(
    parameter int AW  = 8,
    parameter int LVW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [LVW-1:0] levels,
    input  logic [AW-1:0]  start_ptr,
    input  logic           capture,
    input  logic [AW-1:0]  rdata,
    output logic [AW-1:0]  link,
    output logic           last_level
);
    logic [LVW-1:0] remain_q;
    logic [AW-1:0]  link_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            link_q   <= '0;
        end else if (load) begin
            remain_q <= levels;
            link_q   <= start_ptr;
        end else if (capture) begin
            remain_q <= remain_q - LVW'(1);
            link_q   <= rdata;
        end
    end

    assign link       = link_q;
    assign last_level = (remain_q == LVW'(1));
endmodule

// File: rtl/sfseq_limit.sv
module sfseq_limit #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] top,
    input  logic [AW-1:0] extent,
    input  logic [AW-1:0] floor_ptr,
    output logic [AW-1:0] new_high,
    output logic          collide
);
    logic [AW:0] sum;

    always_comb begin
        sum      = {1'b0, top} + {1'b0, extent};
        collide  = sum > {1'b0, floor_ptr};
        new_high = sum[AW-1:0];
    end
endmodule

// File: rtl/sfseq_top.sv
module sfseq_top import sfseq_pkg::*; #(
    parameter int AW       = 8,
    parameter int LVW      = 4,
    parameter int RST_SP   = 4,
    parameter int HEAP_TOP = 240
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_a,
    input  logic [AW-1:0] cmd_b,
    output logic          busy,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] mp,
    output logic [AW-1:0] ep,
    output logic [AW-1:0] np,
    output logic [AW-1:0] pc,
    output logic          exhausted
);
    localparam logic [AW-1:0] SP_INIT   = AW'(RST_SP);
    localparam logic [AW-1:0] HEAP_INIT = AW'(HEAP_TOP);

    seq_state_e    state_q;
    logic [AW-1:0] sp_q, mp_q, ep_q, pc_q;
    logic          exh_q;
    logic [AW-1:0] arg_a_q, arg_b_q, base_q, tmp_ep_q, tmp_dl_q;
    logic          accept, walk_load, walk_cap, walk_last;
    logic [AW-1:0] link, ep_next;
    logic          ep_collide;
    frame_op_e     op;

    assign op        = frame_op_e'(cmd_op);
    assign accept    = cmd_valid && (state_q == S_IDLE) && !exh_q;
    assign walk_load = accept && (op == OP_MARK);
    assign walk_cap  = (state_q == S_WCAP);

    sfseq_link_walker #(.AW(AW), .LVW(LVW)) walker_i (
        .clk(clk), .rst(rst), .load(walk_load), .levels(cmd_a[LVW-1:0]),
        .start_ptr(mp_q), .capture(walk_cap), .rdata(mem_rdata),
        .link(link), .last_level(walk_last)
    );

    sfseq_limit #(.AW(AW)) limit_i (
        .top(sp_q), .extent(cmd_a), .floor_ptr(HEAP_INIT),
        .new_high(ep_next), .collide(ep_collide)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            sp_q     <= SP_INIT;
            mp_q     <= '0;
            ep_q     <= SP_INIT;
            pc_q     <= '0;
            exh_q    <= 1'b0;
            arg_a_q  <= '0;
            arg_b_q  <= '0;
            base_q   <= '0;
            tmp_ep_q <= '0;
            tmp_dl_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (accept) begin
                    arg_a_q <= cmd_a;
                    arg_b_q <= cmd_b;
                    case (op)
                        OP_MARK: begin
                            base_q  <= sp_q + AW'(1);
                            state_q <= (cmd_a[LVW-1:0] != '0) ? S_WALK : S_WSL;
                        end
                        OP_CALL:  state_q <= S_CALL;
                        OP_SETSP: sp_q <= mp_q + cmd_a;
                        OP_SETEP: begin
                            if (ep_collide) exh_q <= 1'b1;
                            else            ep_q  <= ep_next;
                        end
                        OP_RET:   state_q <= S_RA;
                        default:  state_q <= S_IDLE;
                    endcase
                end
                S_WALK: state_q <= S_WCAP;
                S_WCAP: state_q <= walk_last ? S_WSL : S_WALK;
                S_WSL:  state_q <= S_WDL;
                S_WDL:  state_q <= S_WEP;
                S_WEP: begin
                    sp_q    <= sp_q + AW'(HDR_CELLS);
                    state_q <= S_IDLE;
                end
                S_CALL: begin
                    mp_q    <= sp_q - arg_a_q - AW'(HDR_CELLS - 1);
                    pc_q    <= arg_b_q;
                    state_q <= S_IDLE;
                end
                S_RA: state_q <= S_RB;
                S_RB: begin
                    tmp_ep_q <= mem_rdata;
                    state_q  <= S_RC;
                end
                S_RC: begin
                    tmp_dl_q <= mem_rdata;
                    state_q  <= S_RD;
                end
                S_RD: begin
                    pc_q    <= mem_rdata;
                    ep_q    <= tmp_ep_q;
                    mp_q    <= tmp_dl_q;
                    sp_q    <= keeps_result(arg_a_q[1:0]) ? mp_q : mp_q - AW'(1);
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            S_WALK: begin
                mem_en   = 1'b1;
                mem_addr = link + AW'(OFS_SL);
            end
            S_WSL: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = base_q + AW'(OFS_SL); mem_wdata = link;
            end
            S_WDL: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = base_q + AW'(OFS_DL); mem_wdata = mp_q;
            end
            S_WEP: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = base_q + AW'(OFS_EP); mem_wdata = ep_q;
            end
            S_CALL: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr  = sp_q - arg_a_q - AW'(HDR_CELLS - 1) + AW'(OFS_RA);
                mem_wdata = pc_q;
            end
            S_RA: begin mem_en = 1'b1; mem_addr = mp_q + AW'(OFS_EP); end
            S_RB: begin mem_en = 1'b1; mem_addr = mp_q + AW'(OFS_DL); end
            S_RC: begin mem_en = 1'b1; mem_addr = mp_q + AW'(OFS_RA); end
            default: ;
        endcase
    end

    assign busy      = (state_q != S_IDLE);
    assign sp        = sp_q;
    assign mp        = mp_q;
    assign ep        = ep_q;
    assign np        = HEAP_INIT;
    assign pc        = pc_q;
    assign exhausted = exh_q;
endmodule

// File: rtl/sfseq_chk.sv
module sfseq_chk #(
    parameter int AW  = 8,
    parameter int LVW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [AW-1:0] cmd_a,
    input logic          busy,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] mem_wdata,
    input logic [AW-1:0] sp,
    input logic [AW-1:0] mp,
    input logic [AW-1:0] ep,
    input logic [AW-1:0] pc,
    input logic          exhausted
);
    logic take;
    assign take = cmd_valid && !busy && !exhausted;

    p_mark_level0_r2: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_op == 3'd0 && cmd_a[LVW-1:0] == '0) |=>
        (mem_en && mem_we && mem_addr == AW'($past(sp) + AW'(2)) && mem_wdata == $past(mp)));

    p_call_write_r4: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_op == 3'd1) |=>
        (mem_en && mem_we && mem_addr == AW'($past(sp) - $past(cmd_a)) && mem_wdata == $past(pc)));

    p_setsp_r5: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_op == 3'd2) |=> (sp == AW'($past(mp) + $past(cmd_a)) && !busy));

    p_setep_r6: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_op == 3'd3) |=> (exhausted || ep == AW'($past(sp) + $past(cmd_a))));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        exhausted |=> exhausted);

    p_frozen_bus_r8: assert property (@(posedge clk) disable iff (rst)
        exhausted |-> (!mem_en && !busy));

    p_frozen_regs_r8: assert property (@(posedge clk) disable iff (rst)
        exhausted |=> ($stable(sp) && $stable(mp) && $stable(ep) && $stable(pc)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_valid) |=> ($stable(sp) && $stable(mp) && $stable(ep) && $stable(pc)));
endmodule

bind sfseq_top sfseq_chk #(.AW(AW), .LVW(LVW)) chk_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_a(cmd_a),
    .busy(busy), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .sp(sp), .mp(mp), .ep(ep), .pc(pc), .exhausted(exhausted)
);

// File: tb/sfseq_top_tb_top.sv
module sfseq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_a = 8'd0, cmd_b = 8'd0;
    logic       busy, mem_en, mem_we, exhausted;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, sp, mp, ep, np, pc;

    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];
    logic [7:0] m_sp, m_mp, m_ep, m_pc;
    logic       m_exh;
    int tests = 0, fails = 0;
    int exh_mem_hits = 0;

    always #10 clk = ~clk;

    sfseq_top dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sp(sp), .mp(mp), .ep(ep), .np(np), .pc(pc), .exhausted(exhausted)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 256; k++) mem[k] <= 8'd0;
            mem_rdata <= 8'd0;
        end else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
        if (!rst && exhausted && mem_en) exh_mem_hits++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        chk(sp == m_sp, {tag, " sp"}, sp, m_sp);
        chk(mp == m_mp, {tag, " mp"}, mp, m_mp);
        chk(ep == m_ep, {tag, " ep"}, ep, m_ep);
        chk(pc == m_pc, {tag, " pc"}, pc, m_pc);
        chk(exhausted == m_exh, {tag, " exhausted"}, exhausted, m_exh);
    endtask

    task automatic chk_mem(input string tag);
        int bad = 0, first = -1;
        for (int k = 0; k < 256; k++)
            if (mem[k] != ref_mem[k]) begin bad++; if (first < 0) first = k; end
        chk(bad == 0, tag, first < 0 ? 0 : mem[first], first < 0 ? 0 : ref_mem[first]);
    endtask

    // reference model of each command
    task automatic model(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] sl, base, nm, e, d, r;
        logic [8:0] sum;
        if (m_exh) return;
        case (op)
            3'd0: begin
                sl = m_mp;
                for (int k = 0; k < int'(a[3:0]); k++) sl = ref_mem[8'(sl + 8'd1)];
                base = m_sp + 8'd1;
                ref_mem[8'(base + 8'd1)] = sl;
                ref_mem[8'(base + 8'd2)] = m_mp;
                ref_mem[8'(base + 8'd3)] = m_ep;
                m_sp = m_sp + 8'd5;
            end
            3'd1: begin
                nm = m_sp - a - 8'd4;
                ref_mem[8'(nm + 8'd4)] = m_pc;
                m_mp = nm;
                m_pc = b;
            end
            3'd2: m_sp = m_mp + a;
            3'd3: begin
                sum = {1'b0, m_sp} + {1'b0, a};
                if (sum > 9'd240) m_exh = 1'b1; else m_ep = sum[7:0];
            end
            3'd4: begin
                e = ref_mem[8'(m_mp + 8'd3)];
                d = ref_mem[8'(m_mp + 8'd2)];
                r = ref_mem[8'(m_mp + 8'd4)];
                m_sp = (a[1:0] != 2'd0) ? m_mp : m_mp - 8'd1;
                m_mp = d; m_ep = e; m_pc = r;
            end
            default: ;
        endcase
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                         output int busy_cycles);
        busy_cycles = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
        model(op, a, b);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) begin busy_cycles++; @(negedge clk); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int bc;
        logic [2:0] op;
        logic [7:0] a, b;
        void'($urandom(32'd4242));
        for (int k = 0; k < 256; k++) ref_mem[k] = 8'd0;
        m_sp = 8'd4; m_mp = 8'd0; m_ep = 8'd4; m_pc = 8'd0; m_exh = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_regs("R1 reset");
        chk(np == 8'd240, "R1 np", np, 240);
        chk(busy == 1'b0, "R1 busy", busy, 0);

        // R2 header reservation at level 0
        issue(3'd0, 8'd0, 8'd0, bc);
        chk_regs("R2 mark0");
        chk_mem("R2 header cells");
        chk(bc == 3, "R2 busy cycles", bc, 3);
        // R4 transfer
        issue(3'd1, 8'd0, 8'd77, bc);
        chk_regs("R4 call");
        chk_mem("R4 return cell");
        chk(bc == 1, "R4 busy cycles", bc, 1);
        // R5 / R6
        issue(3'd2, 8'd9, 8'd0, bc);
        chk_regs("R5 set sp");
        issue(3'd3, 8'd6, 8'd0, bc);
        chk_regs("R6 set ep");
        // second nested frame then R3 walk of depth 2
        issue(3'd0, 8'd0, 8'd0, bc);
        issue(3'd1, 8'd0, 8'd90, bc);
        issue(3'd2, 8'd7, 8'd0, bc);
        issue(3'd0, 8'd2, 8'd0, bc);
        chk_regs("R3 walk2");
        chk_mem("R3 static link");
        chk(bc == 7, "R3 busy cycles", bc, 7);
        issue(3'd1, 8'd0, 8'd120, bc);
        // R9 leave with result
        issue(3'd4, 8'd2, 8'd0, bc);
        chk_regs("R9 ret value");
        chk(bc == 4, "R9 busy cycles", bc, 4);
        // R9 leave without result
        issue(3'd4, 8'd0, 8'd0, bc);
        chk_regs("R9 ret none");

        // R10 command while busy is dropped
        issue(3'd0, 8'd0, 8'd0, bc);
        issue(3'd1, 8'd0, 8'd33, bc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_a = 8'd3; cmd_b = 8'd0;
        model(3'd0, 8'd3, 8'd0);
        @(negedge clk);
        cmd_op = 3'd2; cmd_a = 8'd99;   // busy is high here
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        chk_regs("R10 dropped while busy");
        chk_mem("R10 memory");
        repeat (3) @(negedge clk);
        chk_regs("R10 idle hold");

        // random mix against the model
        for (int it = 0; it < 300; it++) begin
            op = 3'($urandom_range(0, 4));
            if (m_sp > 8'd180) op = 3'd4;
            if (op == 3'd3 && m_sp > 8'd200) op = 3'd2;
            case (op)
                3'd0: a = 8'($urandom_range(0, 3));
                3'd1: a = 8'($urandom_range(0, 2));
                3'd2: a = 8'($urandom_range(5, 12));
                3'd3: a = 8'($urandom_range(0, 7));
                default: a = 8'($urandom);
            endcase
            b = 8'($urandom);
            issue(op, a, b, bc);
            chk_regs("R2 R4 R5 R6 R9 random");
        end
        chk_mem("R2 R4 random image");

        // R6 / R7 boundary
        issue(3'd2, 8'd20, 8'd0, bc);
        a = 8'd240 - m_sp;
        issue(3'd3, a, 8'd0, bc);
        chk_regs("R6 equal floor");
        chk(exhausted == 1'b0, "R6 no flag at floor", exhausted, 0);
        issue(3'd3, a + 8'd1, 8'd0, bc);
        chk_regs("R7 collision");
        chk(exhausted == 1'b1, "R7 flag", exhausted, 1);
        // R8 frozen
        issue(3'd0, 8'd1, 8'd0, bc);
        issue(3'd4, 8'd1, 8'd0, bc);
        issue(3'd2, 8'd3, 8'd0, bc);
        chk_regs("R8 frozen");
        chk(exh_mem_hits == 0, "R8 no memory access", exh_mem_hits, 0);
        chk(exhausted == 1'b1, "R7 sticky", exhausted, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule